// File: doc/BRIEF.md
# AXI Address-Channel Traffic Throttle

This block sits on the address channels between an AXI manager and an AXI subordinate. It sets the pace at which read and write addresses are let through. It does not move any payload. The AR and AW valid/ready pairs pass through a combinational gate. The R, W and B handshakes are only observed, so that the gate can track how much work is in flight and how much data has moved. Data beats of transactions that were already accepted are never held back.

Three kinds of limit close the gate:
- Caps on pending reads, pending writes and pending reads plus writes.
- A repeating window of open cycles followed by closed cycles.
- A budget of 64-bit data beats for each window period.

Every limit comes from a static configuration input. It is set while reset is asserted and held afterwards. A cap of zero means no cap. When both an AR and an AW are eligible in the same cycle and only one slot is left under the combined cap, the read takes the slot.

Top module: `axi_addr_throttle`

## Requirements
- R1: Reads pending: the count rises on each AR handshake and falls on each R handshake with `r_last`=1. While `cfg_rd_max` is nonzero and the count equals it, `mgr_arready` and `sub_arvalid` are 0. With `cfg_rd_max`=0 this cap never blocks.
- R2: Writes pending: the count rises on each AW handshake and falls on each B handshake. While `cfg_wr_max` is nonzero and the count equals it, `mgr_awready` and `sub_awvalid` are 0. With `cfg_wr_max`=0 this cap never blocks.
- R3: While `cfg_all_max` is nonzero, the sum of pending reads and writes never exceeds it. An AR is eligible when `mgr_arvalid`=1 and every read-side condition holds (window, budget, read cap, combined sum below the cap). In a cycle with an eligible AR, an AW needs the sum plus one to stay below `cfg_all_max`.
- R4: The window opens in the first cycle after reset. It stays open for `cfg_on_len` cycles, then closed for `cfg_off_len` cycles, and repeats. With `cfg_off_len`=0 it is always open. With `cfg_on_len`=0 and `cfg_off_len`>0 it is always closed. No address handshake occurs while the window is closed.
- R5: The beat count sums the R handshakes and W handshakes in each cycle. It restarts at zero in the first cycle of every period. That is the first open cycle, or every `cfg_on_len` cycles (at least 1) when `cfg_off_len`=0. The beats of that first cycle count toward the new period. While `cfg_beat_cap` is nonzero and the count is at or above it, both address channels are blocked. With `cfg_beat_cap`=0 the budget never blocks.
- R6: When the gate for a channel is open, `mgr_xready` equals `sub_xready` and `sub_xvalid` equals `mgr_xvalid` in the same cycle. When it is shut, both outputs are 0.
- R7: After reset, nothing is pending, the beat count is zero, and the window starts at the first cycle of an open phase.
- R8: A read that retires and a new read accepted in the same cycle leave the pending count unchanged. The same holds for a write that retires and a new write accepted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_max | input | 6 | Cap on pending reads, 0 = none |
| cfg_wr_max | input | 6 | Cap on pending writes, 0 = none |
| cfg_all_max | input | 6 | Cap on pending reads plus writes, 0 = none |
| cfg_on_len | input | 16 | Open cycles per period |
| cfg_off_len | input | 16 | Closed cycles per period, 0 = always open |
| cfg_beat_cap | input | 16 | Data beats allowed per period, 0 = none |
| mgr_arvalid | input | 1 | Read address valid from the manager |
| mgr_arready | output | 1 | Read address ready to the manager |
| sub_arvalid | output | 1 | Read address valid to the subordinate |
| sub_arready | input | 1 | Read address ready from the subordinate |
| mgr_awvalid | input | 1 | Write address valid from the manager |
| mgr_awready | output | 1 | Write address ready to the manager |
| sub_awvalid | output | 1 | Write address valid to the subordinate |
| sub_awready | input | 1 | Write address ready from the subordinate |
| r_valid | input | 1 | Observed read data valid |
| r_ready | input | 1 | Observed read data ready |
| r_last | input | 1 | Observed last beat of a read burst |
| w_valid | input | 1 | Observed write data valid |
| w_ready | input | 1 | Observed write data ready |
| b_valid | input | 1 | Observed write response valid |
| b_ready | input | 1 | Observed write response ready |

## Verification
The gate outputs are combinational. They respond to the valid and ready inputs in the same cycle. A handshake changes a pending count or the beat count one clock later, so the gate reflects it from the next cycle on.

The bench drives inputs on the falling edge and waits for them to settle. It then compares all four gate outputs against a model that keeps its own pending counts and beat count from the observed handshakes. The model derives the window phase from the cycle index since reset, using period arithmetic. After the comparison it advances its state by exactly one cycle, matching the single register stage in the design.

// File: rtl/thr_pkg.sv
package thr_pkg;
   // Phase of the address window
   typedef enum logic {
      PH_OPEN   = 1'b0,
      PH_CLOSED = 1'b1
   } win_phase_e;

   localparam int unsigned DEF_LIM_W  = 6;
   localparam int unsigned DEF_TIME_W = 16;
   localparam int unsigned DEF_CAP_W  = 16;
endpackage

// File: rtl/thr_pend_ctr.sv
module thr_pend_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("thr_pend_ctr: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (inc && !dec) begin
         if (count != CNT_TOP) count <= count + 1'b1;
      end else if (dec && !inc) begin
         if (count != '0) count <= count - 1'b1;
      end
   end

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |-> (count != '0));

   // R8
   pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec) |=> $stable(count));
endmodule

// File: rtl/thr_window.sv
module thr_window
   import thr_pkg::*;
#(
   parameter int unsigned TIME_W = DEF_TIME_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] cfg_on_len,
   input  logic [TIME_W-1:0] cfg_off_len,
   output logic              win_open,
   output logic              period_start
);
   localparam int unsigned SUM_W = TIME_W + 1;

   generate
      if (TIME_W < 2) begin : g_bad_w
         $error("thr_window: TIME_W must be at least 2");
      end
   endgenerate

   win_phase_e        phase;
   logic [TIME_W-1:0] tick;
   logic [SUM_W-1:0]  tick_nx;
   logic              on_done, off_done;

   assign tick_nx  = {1'b0, tick} + 1'b1;
   assign on_done  = (cfg_on_len == '0) || (tick_nx >= {1'b0, cfg_on_len});
   assign off_done = tick_nx >= {1'b0, cfg_off_len};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_OPEN;
         tick  <= '0;
      end else if (phase == PH_OPEN) begin
         if (on_done) begin
            tick  <= '0;
            phase <= (cfg_off_len == '0) ? PH_OPEN : PH_CLOSED;
         end else begin
            tick <= tick_nx[TIME_W-1:0];
         end
      end else begin
         if (off_done) begin
            tick  <= '0;
            phase <= PH_OPEN;
         end else begin
            tick <= tick_nx[TIME_W-1:0];
         end
      end
   end

   assign win_open     = (cfg_off_len == '0) ||
                         ((phase == PH_OPEN) && (cfg_on_len != '0));
   assign period_start = (phase == PH_OPEN) && (tick == '0);

   // R4
   on_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_OPEN) && (cfg_on_len != '0)) |-> (tick < cfg_on_len));

   // R4
   off_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CLOSED) |-> ((cfg_off_len != '0) && (tick < cfg_off_len)));
endmodule

// File: rtl/thr_budget.sv
module thr_budget
   import thr_pkg::*;
#(
   parameter int unsigned CAP_W = DEF_CAP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CAP_W-1:0] cfg_beat_cap,
   input  logic             period_start,
   input  logic [1:0]       beats,
   output logic             below_cap
);
   localparam int unsigned BC_W = CAP_W + 1;
   localparam logic [BC_W-1:0] BC_TOP = {BC_W{1'b1}};

   generate
      if (CAP_W < 2) begin : g_bad_w
         $error("thr_budget: CAP_W must be at least 2");
      end
   endgenerate

   logic [BC_W-1:0] used;
   logic [BC_W-1:0] used_eff;
   logic [BC_W:0]   used_sum;

   assign used_eff = period_start ? '0 : used;
   assign used_sum = {1'b0, used_eff} + {{(BC_W-1){1'b0}}, beats};

   always_ff @(posedge clk) begin
      if (!rst_n) used <= '0;
      else        used <= used_sum[BC_W] ? BC_TOP : used_sum[BC_W-1:0];
   end

   assign below_cap = (cfg_beat_cap == '0) || (used_eff < {1'b0, cfg_beat_cap});

   // R5
   fresh_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |-> below_cap);
endmodule

// File: rtl/axi_addr_throttle.sv
module axi_addr_throttle
   import thr_pkg::*;
#(
   parameter int unsigned LIM_W      = DEF_LIM_W,
   parameter int unsigned TIME_W     = DEF_TIME_W,
   parameter int unsigned CAP_W      = DEF_CAP_W,
   parameter bit          USE_BUDGET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIM_W-1:0]  cfg_rd_max,
   input  logic [LIM_W-1:0]  cfg_wr_max,
   input  logic [LIM_W-1:0]  cfg_all_max,
   input  logic [TIME_W-1:0] cfg_on_len,
   input  logic [TIME_W-1:0] cfg_off_len,
   input  logic [CAP_W-1:0]  cfg_beat_cap,
   input  logic              mgr_arvalid,
   output logic              mgr_arready,
   output logic              sub_arvalid,
   input  logic              sub_arready,
   input  logic              mgr_awvalid,
   output logic              mgr_awready,
   output logic              sub_awvalid,
   input  logic              sub_awready,
   input  logic              r_valid,
   input  logic              r_ready,
   input  logic              r_last,
   input  logic              w_valid,
   input  logic              w_ready,
   input  logic              b_valid,
   input  logic              b_ready
);
   localparam int unsigned CNT_W = LIM_W + 2;
   localparam int unsigned SUM_W = CNT_W + 1;

   generate
      if (LIM_W < 1) begin : g_bad_lim
         $error("axi_addr_throttle: LIM_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] rd_pend, wr_pend;
   logic [SUM_W-1:0] all_pend, all_pend_ar;
   logic             win_open, period_start, below_cap;
   logic             rd_room, wr_room, all_room_ar, all_room_aw;
   logic             gate_common, ar_grant, aw_grant, ar_claim;
   logic             ar_fire, aw_fire, rd_done, wr_done;
   logic [1:0]       beats;

   assign ar_fire = mgr_arvalid && sub_arready && ar_grant;
   assign aw_fire = mgr_awvalid && sub_awready && aw_grant;
   assign rd_done = r_valid && r_ready && r_last;
   assign wr_done = b_valid && b_ready;
   assign beats   = {1'b0, r_valid && r_ready} + {1'b0, w_valid && w_ready};

   thr_pend_ctr #(.CNT_W(CNT_W)) u_rd_pend (
      .clk(clk), .rst_n(rst_n), .inc(ar_fire), .dec(rd_done), .count(rd_pend));

   thr_pend_ctr #(.CNT_W(CNT_W)) u_wr_pend (
      .clk(clk), .rst_n(rst_n), .inc(aw_fire), .dec(wr_done), .count(wr_pend));

   thr_window #(.TIME_W(TIME_W)) u_window (
      .clk(clk), .rst_n(rst_n), .cfg_on_len(cfg_on_len), .cfg_off_len(cfg_off_len),
      .win_open(win_open), .period_start(period_start));

   generate
      if (USE_BUDGET) begin : g_budget
         thr_budget #(.CAP_W(CAP_W)) u_budget (
            .clk(clk), .rst_n(rst_n), .cfg_beat_cap(cfg_beat_cap),
            .period_start(period_start), .beats(beats), .below_cap(below_cap));
      end else begin : g_no_budget
         assign below_cap = 1'b1;
      end
   endgenerate

   // Cap checks: zero disables each cap
   assign all_pend    = {1'b0, rd_pend} + {1'b0, wr_pend};
   assign rd_room     = (cfg_rd_max == '0) ||
                        (rd_pend < {{(CNT_W-LIM_W){1'b0}}, cfg_rd_max});
   assign wr_room     = (cfg_wr_max == '0) ||
                        (wr_pend < {{(CNT_W-LIM_W){1'b0}}, cfg_wr_max});
   assign all_room_ar = (cfg_all_max == '0) ||
                        (all_pend < {{(SUM_W-LIM_W){1'b0}}, cfg_all_max});

   assign gate_common = win_open && below_cap;
   assign ar_grant    = gate_common && rd_room && all_room_ar;
   assign ar_claim    = ar_grant && mgr_arvalid;

   // Reads take the last combined slot
   assign all_pend_ar = all_pend + {{(SUM_W-1){1'b0}}, ar_claim};
   assign all_room_aw = (cfg_all_max == '0) ||
                        (all_pend_ar < {{(SUM_W-LIM_W){1'b0}}, cfg_all_max});
   assign aw_grant    = gate_common && wr_room && all_room_aw;

   assign mgr_arready = sub_arready && ar_grant;
   assign sub_arvalid = mgr_arvalid && ar_grant;
   assign mgr_awready = sub_awready && aw_grant;
   assign sub_awvalid = mgr_awvalid && aw_grant;

   // R1
   rd_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_max != '0) |-> (rd_pend <= {{(CNT_W-LIM_W){1'b0}}, cfg_rd_max}));

   // R2
   wr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_max != '0) |-> (wr_pend <= {{(CNT_W-LIM_W){1'b0}}, cfg_wr_max}));

   // R3
   all_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_all_max != '0) |-> (all_pend <= {{(SUM_W-LIM_W){1'b0}}, cfg_all_max}));

   // R4
   closed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open |-> !(sub_arvalid && sub_arready) && !(sub_awvalid && sub_awready));

   // R5
   budget_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !below_cap |-> !sub_arvalid && !sub_awvalid);

   // R6
   ar_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_arvalid |-> mgr_arvalid) and (mgr_arready |-> sub_arready));

   // R6
   aw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_awvalid |-> mgr_awvalid) and (mgr_awready |-> sub_awready));
endmodule

// File: tb/tb_axi_addr_throttle.sv
`timescale 1ns/1ps
module tb_axi_addr_throttle;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_rd_max = '0, cfg_wr_max = '0, cfg_all_max = '0;
   logic [15:0] cfg_on_len = '0, cfg_off_len = '0, cfg_beat_cap = '0;
   logic        mgr_arvalid = 0, sub_arready = 0, mgr_awvalid = 0, sub_awready = 0;
   logic        r_valid = 0, r_ready = 0, r_last = 0, w_valid = 0, w_ready = 0;
   logic        b_valid = 0, b_ready = 0;
   logic        mgr_arready, sub_arvalid, mgr_awready, sub_awvalid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   axi_addr_throttle dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_rd_max(cfg_rd_max), .cfg_wr_max(cfg_wr_max), .cfg_all_max(cfg_all_max),
      .cfg_on_len(cfg_on_len), .cfg_off_len(cfg_off_len), .cfg_beat_cap(cfg_beat_cap),
      .mgr_arvalid(mgr_arvalid), .mgr_arready(mgr_arready),
      .sub_arvalid(sub_arvalid), .sub_arready(sub_arready),
      .mgr_awvalid(mgr_awvalid), .mgr_awready(mgr_awready),
      .sub_awvalid(sub_awvalid), .sub_awready(sub_awready),
      .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
      .w_valid(w_valid), .w_ready(w_ready),
      .b_valid(b_valid), .b_ready(b_ready));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // Model state
   int m_rd, m_wr, m_used, t;

   function automatic bit win_open_at(int tt, int on, int off);
      if (off == 0) return 1'b1;
      if (on == 0) return 1'b0;
      return (tt % (on + off)) < on;
   endfunction

   function automatic bit period_start_at(int tt, int on, int off);
      if (off == 0) return (tt % ((on == 0) ? 1 : on)) == 0;
      return (tt % (((on == 0) ? 1 : on) + off)) == 0;
   endfunction

   task automatic drive_random();
      mgr_arvalid = ($urandom_range(0, 9) < 6);
      sub_arready = ($urandom_range(0, 9) < 7);
      mgr_awvalid = ($urandom_range(0, 9) < 6);
      sub_awready = ($urandom_range(0, 9) < 7);
      r_valid     = (m_rd > 0) && ($urandom_range(0, 9) < 8);
      r_ready     = ($urandom_range(0, 9) < 8);
      r_last      = $urandom_range(0, 1);
      w_valid     = ($urandom_range(0, 9) < 5);
      w_ready     = ($urandom_range(0, 9) < 7);
      b_valid     = (m_wr > 0) && ($urandom_range(0, 9) < 7);
      b_ready     = ($urandom_range(0, 9) < 8);
   endtask

   task automatic run_cfg(input int rdm, input int wrm, input int allm,
                          input int on, input int off, input int cap, input int ncyc);
      bit open_w, ps, bud_ok, ar_g, aw_g, ar_claim, ar_f, aw_f, rd_d, wr_d;
      int eff, tot, bts;
      rst_n = 1'b0;
      cfg_rd_max = rdm[5:0]; cfg_wr_max = wrm[5:0]; cfg_all_max = allm[5:0];
      cfg_on_len = on[15:0]; cfg_off_len = off[15:0]; cfg_beat_cap = cap[15:0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_rd = 0; m_wr = 0; m_used = 0; t = 0;
      // cycle 0: both address channels offered and ready
      mgr_arvalid = 1; sub_arready = 1; mgr_awvalid = 1; sub_awready = 1;
      r_valid = 0; w_valid = 0; b_valid = 0; r_ready = 0; w_ready = 0; b_ready = 0;
      r_last = 0;
      for (int i = 0; i < ncyc; i++) begin
         #1;
         open_w = win_open_at(t, on, off);
         ps     = period_start_at(t, on, off);
         eff    = ps ? 0 : m_used;
         bud_ok = (cap == 0) || (eff < cap);
         tot    = m_rd + m_wr;
         ar_g   = open_w && bud_ok && ((rdm == 0) || (m_rd < rdm)) &&
                  ((allm == 0) || (tot < allm));
         ar_claim = ar_g && mgr_arvalid;
         aw_g   = open_w && bud_ok && ((wrm == 0) || (m_wr < wrm)) &&
                  ((allm == 0) || (tot + int'(ar_claim) < allm));
         if (t == 0) begin
            // R7: fresh state after reset, window at start of open phase
            chk(mgr_arready == ar_g, "R7 ar ready after reset", mgr_arready, ar_g);
            chk(mgr_awready == aw_g, "R7 aw ready after reset", mgr_awready, aw_g);
         end
         // R6 R8: full gate comparison against the model
         chk(mgr_arready == (sub_arready && ar_g), "R6 R8 mgr_arready",
             mgr_arready, sub_arready && ar_g);
         chk(sub_arvalid == (mgr_arvalid && ar_g), "R6 R8 sub_arvalid",
             sub_arvalid, mgr_arvalid && ar_g);
         chk(mgr_awready == (sub_awready && aw_g), "R6 R8 mgr_awready",
             mgr_awready, sub_awready && aw_g);
         chk(sub_awvalid == (mgr_awvalid && aw_g), "R6 R8 sub_awvalid",
             sub_awvalid, mgr_awvalid && aw_g);
         if (!open_w)
            chk(!sub_arvalid && !sub_awvalid, "R4 closed window blocks",
                sub_arvalid + sub_awvalid, 0);
         if (!bud_ok)
            chk(!sub_arvalid && !sub_awvalid, "R5 budget spent blocks",
                sub_arvalid + sub_awvalid, 0);
         if (rdm != 0 && m_rd == rdm)
            chk(!mgr_arready && !sub_arvalid, "R1 read cap blocks", mgr_arready, 0);
         if (wrm != 0 && m_wr == wrm)
            chk(!mgr_awready && !sub_awvalid, "R2 write cap blocks", mgr_awready, 0);
         if (allm != 0 && ar_claim && tot + 1 == allm)
            chk(!sub_awvalid && !mgr_awready, "R3 read takes last slot", sub_awvalid, 0);
         // advance model by one cycle
         ar_f = mgr_arvalid && sub_arready && ar_g;
         aw_f = mgr_awvalid && sub_awready && aw_g;
         rd_d = r_valid && r_ready && r_last;
         wr_d = b_valid && b_ready;
         bts  = int'(r_valid && r_ready) + int'(w_valid && w_ready);
         m_rd = m_rd + int'(ar_f) - int'(rd_d);
         m_wr = m_wr + int'(aw_f) - int'(wr_d);
         m_used = eff + bts;
         if (rdm != 0) chk(m_rd <= rdm, "R1 pending reads bound", m_rd, rdm);
         if (wrm != 0) chk(m_wr <= wrm, "R2 pending writes bound", m_wr, wrm);
         if (allm != 0) chk(m_rd + m_wr <= allm, "R3 combined bound", m_rd + m_wr, allm);
         t++;
         @(negedge clk);
         drive_random();
      end
   endtask

   initial begin
      run_cfg(0, 0, 0,    5,  3,    0,  600);
      run_cfg(2, 3, 0,    7,  0,    0,  600);
      run_cfg(1, 1, 1,    4,  2,    0,  600);
      run_cfg(3, 2, 4,    6,  2,    5,  800);
      run_cfg(0, 0, 0,    0,  4,    0,  300);
      run_cfg(2, 0, 0,  320, 80,   50, 1300);
      run_cfg(8, 8, 0, 3999,  1, 4000, 1500);
      run_cfg(0, 0, 2,    0,  0,    1,  600);
      run_cfg(0, 4, 3,   10,  5,    3,  800);
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule